// File: doc/BRIEF.md
# Latch-type DAC serial word formatter

This block feeds a two-channel audio DAC that takes its samples serially and transfers them to its output on a latch pulse. The whole block runs on one master clock. A fixed divider of that clock sets the word period. At the start of every word period a latch pulse is raised, and its timing depends on nothing except that divider. At that same moment one sample per channel is taken from that channel's show-ahead FIFO. After the latch pulse falls, the block holds a programmable quiet window so the converter can settle. It then shifts the new samples out, MSB first, on a bit clock. That bit clock is made from the master clock, and its rate depends only on the selected word length.

The word length can be 16, 18, 20 or 24 bits. For a given length the bit clock half-period is WORD_PERIOD / (2 × (length + BIT_SPARE)) master clocks, rounded down. With the defaults (256 master clocks per word) this gives half-periods of 5, 4, 4 and 4 clocks. The quiet window is counted in whole bit clock cycles. The block clamps it so that the latch pulse, the quiet window and the word together always fit inside one word period. If a FIFO is empty when a word starts, the previous word of that channel is sent again and that channel's underrun flag is raised for the word period.

Top module: `dac_latch_fmt`

## Requirements
- R1: `dac_latch` is high for exactly LATCH_W (default 4) master clocks at the start of every WORD_PERIOD (default 256) clock period, counted from the first clock after reset is released. Neither `wl_sel` nor `quiet_in` changes this.
- R2: `wl_sel` selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Each word period contains exactly that many bit clock high pulses.
- R3: Each bit clock cycle lasts 2H master clocks, low for H and then high for H. H = WORD_PERIOD / (2 × (length + BIT_SPARE)), with BIT_SPARE defaulting to 8.
- R4: After `dac_latch` falls, `dac_bclk` stays low for Q full bit clock cycles before the first bit cycle starts. The first rising bit clock edge therefore comes Q×2H + H clocks after the latch falls. `dac_bclk` is never high while `dac_latch` is high.
- R5: Q is `quiet_in`, clamped to (WORD_PERIOD − LATCH_W) / (2H) − length. With the defaults the clamp limits are 9, 13, 11 and 7 for lengths 16, 18, 20 and 24.
- R6: The shifted bits are the top `length` bits of the 24-bit sample, MSB (bit 23) first. A data line changes only at the start of a bit cycle's low phase, stays stable while `dac_bclk` is high, and holds its last bit between words.
- R7: Each FIFO pop output is high for one clock, at the word start, only when that FIFO is not empty. The sample presented on that clock is the one that is sent.
- R8: If a FIFO is empty at the word start, the channel's previous word is sent again (zero if there is none since reset) and its underrun flag is high for that word period. The flag is low for any word that was popped.
- R9: Both channels share one latch pulse and one bit clock, and each channel has its own data line carrying its own samples.
- R10: `wl_sel` and `quiet_in` are sampled only at the word start. A change in the middle of a word has no effect on that word.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wl_sel | input | 2 | Word length select (0:16, 1:18, 2:20, 3:24) |
| quiet_in | input | QW | Requested quiet window, in bit clock cycles |
| l_empty | input | 1 | Left FIFO empty |
| l_data | input | DW | Left FIFO head sample |
| l_pop | output | 1 | Left FIFO pop |
| r_empty | input | 1 | Right FIFO empty |
| r_data | input | DW | Right FIFO head sample |
| r_pop | output | 1 | Right FIFO pop |
| dac_latch | output | 1 | Word-rate latch pulse |
| dac_bclk | output | 1 | Bit clock |
| dac_sd_l | output | 1 | Left serial data |
| dac_sd_r | output | 1 | Right serial data |
| l_underrun | output | 1 | Left word repeated for this word period |
| r_underrun | output | 1 | Right word repeated for this word period |

## Verification
All four word lengths are run, each with a different quiet request. One of those requests lies past the clamp limit for its length, which separates an unclamped window from a clamped one. The first samples are all-ones and a pattern with only the MSB and LSB set, and the rest are random, with different values on the two channels. These show whether bit order, truncation and channel separation are right. The settings are changed at arbitrary points inside a word, which shows whether they are sampled only at the word start. A run with both FIFOs empty, including the very first word after reset, separates a correct repeat of the last word from sending stale or zero data.

// File: rtl/dacfmt_pkg.sv
// Package: shared configuration type and elaboration-time helpers for the
// latch-type DAC formatter. Assumes WORD_PERIOD is large enough that every
// bit clock half-period computes to at least one master clock.
package dacfmt_pkg;

    localparam int CFG_W = 8;

    // Word configuration captured at each word start
    typedef struct packed {
        logic [CFG_W-1:0] len;
        logic [CFG_W-1:0] half;
        logic [CFG_W-1:0] quiet;
    } cfg_t;

    // Word length in bits for a select code
    function automatic int wl_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    // Bit clock half-period in master clocks for a given word length
    function automatic int bit_half(input int len, input int wp, input int spare);
        return wp / (2 * (len + spare));
    endfunction

    // Largest quiet window (bit clock cycles) that still fits the word period
    function automatic int quiet_max(input int len, input int wp, input int lw, input int spare);
        int h;
        int r;
        h = bit_half(len, wp, spare);
        if (h == 0) return 0;
        r = (wp - lw) / (2 * h) - len;
        return (r < 0) ? 0 : r;
    endfunction

endpackage

// File: rtl/fmt_cfg_latch.sv
// Module: fmt_cfg_latch
// Decodes the word length select into length, bit clock half-period and
// quiet-window limit, clamps the requested quiet window, and registers the
// result at each word start. Assumes word_start is a single-cycle strobe.
module fmt_cfg_latch
    import dacfmt_pkg::*;
#(
    parameter int WORD_PERIOD = 256,
    parameter int LATCH_W     = 4,
    parameter int BIT_SPARE   = 8,
    parameter int QW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_start,
    input  logic [1:0]    wl_sel,
    input  logic [QW-1:0] quiet_in,
    output cfg_t          cfg_q
);

    localparam int N_SEL = 4;

    logic [CFG_W-1:0] len_lut  [N_SEL];
    logic [CFG_W-1:0] half_lut [N_SEL];
    logic [CFG_W-1:0] qmax_lut [N_SEL];

    // Constant per-length tables, one entry per select code
    for (genvar i = 0; i < N_SEL; i++) begin : g_lut
        localparam int LEN_I  = wl_bits(2'(i));
        localparam int HALF_I = bit_half(LEN_I, WORD_PERIOD, BIT_SPARE);
        localparam int QMAX_I = quiet_max(LEN_I, WORD_PERIOD, LATCH_W, BIT_SPARE);
        assign len_lut[i]  = CFG_W'(LEN_I);
        assign half_lut[i] = CFG_W'(HALF_I);
        assign qmax_lut[i] = CFG_W'(QMAX_I);
    end

    logic [CFG_W-1:0] q_ext;
    logic [CFG_W-1:0] q_lim;
    cfg_t             cfg_d;

    // Select the table entries and clamp the quiet request
    always_comb begin
        q_ext       = CFG_W'(quiet_in);
        q_lim       = qmax_lut[wl_sel];
        cfg_d.len   = len_lut[wl_sel];
        cfg_d.half  = half_lut[wl_sel];
        cfg_d.quiet = (q_ext > q_lim) ? q_lim : q_ext;
    end

    // Hold the configuration for the whole word period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (word_start) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/fmt_word_timer.sv
// Module: fmt_word_timer
// Divides the master clock into word periods, produces the latch pulse at
// the start of each, then times the quiet window and the bit cycles of the
// word from the registered configuration. The bit clock phase restarts when
// the latch pulse ends; its rate comes from cfg.half only.
// Assumes LATCH_W >= 1 and that the configuration fits the word period.
module fmt_word_timer
    import dacfmt_pkg::*;
#(
    parameter int WORD_PERIOD = 256,
    parameter int LATCH_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    output logic word_start,
    output logic shift_stb,
    output logic latch_o,
    output logic bclk_o
);

    localparam int              WC_W    = $clog2(WORD_PERIOD);
    localparam int              CNT_W   = CFG_W + 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WORD_PERIOD - 1);
    localparam logic [WC_W-1:0] LW_C    = WC_W'(LATCH_W);

    logic [WC_W-1:0]  wc;
    logic [CNT_W-1:0] pc;
    logic [CNT_W-1:0] bc;
    logic [CNT_W-1:0] ph_last;
    logic [CNT_W-1:0] half_c;
    logic [CNT_W-1:0] first_bit;
    logic [CNT_W-1:0] end_bit;
    logic             in_latch;
    logic             active;

    // Decode the current position inside the word period
    always_comb begin
        in_latch   = (wc < LW_C);
        word_start = (wc == '0);
        ph_last    = {cfg.half, 1'b0} - 1'b1;
        half_c     = {1'b0, cfg.half};
        first_bit  = {1'b0, cfg.quiet};
        end_bit    = {1'b0, cfg.quiet} + {1'b0, cfg.len};
        active     = !in_latch && (bc >= first_bit) && (bc < end_bit);
        shift_stb  = active && (pc == '0);
    end

    // Word period divider on the master clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc <= '0;
        end else if (wc == WC_LAST) begin
            wc <= '0;
        end else begin
            wc <= wc + 1'b1;
        end
    end

    // Bit clock phase and bit cycle counters, restarted during the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            bc <= '0;
        end else if (in_latch) begin
            pc <= '0;
            bc <= '0;
        end else if (pc == ph_last) begin
            pc <= '0;
            bc <= bc + 1'b1;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // Registered latch and bit clock outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= 1'b0;
            bclk_o  <= 1'b0;
        end else begin
            latch_o <= in_latch;
            bclk_o  <= active && (pc >= half_c);
        end
    end

endmodule

// File: rtl/fmt_chan_shift.sv
// Module: fmt_chan_shift
// One channel: pops its FIFO at the word start, or reuses the last word on
// an empty FIFO, and shifts the word out MSB first on each shift strobe.
// Assumes a show-ahead FIFO whose head is valid whenever it is not empty,
// and that word_start and shift_stb never coincide.
module fmt_chan_shift #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_start,
    input  logic          shift_stb,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic          dout,
    output logic          underrun
);

    logic [DW-1:0] sh;
    logic [DW-1:0] last_w;

    // Take one word per word period from a non-empty FIFO
    assign fifo_pop = rst_n && word_start && !fifo_empty;

    // Load, repeat or shift the channel word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            last_w   <= '0;
            dout     <= 1'b0;
            underrun <= 1'b0;
        end else if (word_start) begin
            if (!fifo_empty) begin
                sh       <= fifo_data;
                last_w   <= fifo_data;
                underrun <= 1'b0;
            end else begin
                sh       <= last_w;
                underrun <= 1'b1;
            end
        end else if (shift_stb) begin
            dout <= sh[DW-1];
            sh   <= {sh[DW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/dac_latch_fmt.sv
// Module: dac_latch_fmt (top)
// Two-channel serial formatter for a latch-type DAC: word-rate latch from
// the master clock divider, length-dependent bit clock, quiet window after
// each latch, per-channel FIFO read with repeat on underrun.
// Assumes DW >= 24 so every selectable word length fits the sample.
module dac_latch_fmt
    import dacfmt_pkg::*;
#(
    parameter int WORD_PERIOD = 256,
    parameter int LATCH_W     = 4,
    parameter int BIT_SPARE   = 8,
    parameter int DW          = 24,
    parameter int QW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wl_sel,
    input  logic [QW-1:0] quiet_in,
    input  logic          l_empty,
    input  logic [DW-1:0] l_data,
    output logic          l_pop,
    input  logic          r_empty,
    input  logic [DW-1:0] r_data,
    output logic          r_pop,
    output logic          dac_latch,
    output logic          dac_bclk,
    output logic          dac_sd_l,
    output logic          dac_sd_r,
    output logic          l_underrun,
    output logic          r_underrun
);

    localparam int N_CH = 2;

    cfg_t                    cfg_q;
    logic                    word_start;
    logic                    shift_stb;
    logic [N_CH-1:0]         emp_v;
    logic [N_CH-1:0][DW-1:0] dat_v;
    logic [N_CH-1:0]         pop_v;
    logic [N_CH-1:0]         sd_v;
    logic [N_CH-1:0]         ur_v;

    fmt_cfg_latch #(
        .WORD_PERIOD(WORD_PERIOD),
        .LATCH_W    (LATCH_W),
        .BIT_SPARE  (BIT_SPARE),
        .QW         (QW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_start(word_start),
        .wl_sel    (wl_sel),
        .quiet_in  (quiet_in),
        .cfg_q     (cfg_q)
    );

    fmt_word_timer #(
        .WORD_PERIOD(WORD_PERIOD),
        .LATCH_W    (LATCH_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_q),
        .word_start(word_start),
        .shift_stb (shift_stb),
        .latch_o   (dac_latch),
        .bclk_o    (dac_bclk)
    );

    // Gather the per-channel FIFO inputs into vectors
    assign emp_v = {r_empty, l_empty};
    assign dat_v = {r_data, l_data};

    // One shifter per channel on the shared timing
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        fmt_chan_shift #(
            .DW(DW)
        ) u_sh (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_start(word_start),
            .shift_stb (shift_stb),
            .fifo_empty(emp_v[c]),
            .fifo_data (dat_v[c]),
            .fifo_pop  (pop_v[c]),
            .dout      (sd_v[c]),
            .underrun  (ur_v[c])
        );
    end

    // Spread the channel vectors onto the ports
    assign l_pop      = pop_v[0];
    assign r_pop      = pop_v[1];
    assign dac_sd_l   = sd_v[0];
    assign dac_sd_r   = sd_v[1];
    assign l_underrun = ur_v[0];
    assign r_underrun = ur_v[1];

endmodule

// File: rtl/dac_latch_fmt_chk.sv
// Module: dac_latch_fmt_chk
// Checker for dac_latch_fmt, attached with bind. Watches only the ports.
module dac_latch_fmt_chk #(
    parameter int LATCH_W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic dac_latch,
    input logic dac_bclk,
    input logic dac_sd_l,
    input logic dac_sd_r,
    input logic l_pop,
    input logic r_pop,
    input logic l_underrun,
    input logic r_underrun
);

    int le_run;

    // Count consecutive latch-high cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            le_run <= 0;
        end else if (dac_latch) begin
            le_run <= le_run + 1;
        end else begin
            le_run <= 0;
        end
    end

    p_latch_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dac_latch |-> (le_run < LATCH_W));

    p_bclk_low_in_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_latch |-> !dac_bclk);

    p_data_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_bclk && $past(dac_bclk)) |-> ($stable(dac_sd_l) && $stable(dac_sd_r)));

    p_pop_at_word_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_pop || r_pop) |=> dac_latch);

    p_no_flag_after_pop_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        l_pop |=> !l_underrun);

    p_no_flag_after_pop_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_pop |=> !r_underrun);

endmodule

bind dac_latch_fmt dac_latch_fmt_chk #(.LATCH_W(LATCH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_latch (dac_latch),
    .dac_bclk  (dac_bclk),
    .dac_sd_l  (dac_sd_l),
    .dac_sd_r  (dac_sd_r),
    .l_pop     (l_pop),
    .r_pop     (r_pop),
    .l_underrun(l_underrun),
    .r_underrun(r_underrun)
);

// File: tb/sim_dac_latch_fmt.sv
// Bench for dac_latch_fmt: behavioural per-cycle model compared on every clock.
module sim_dac_latch_fmt;

    localparam int WP = 256;
    localparam int LW = 4;
    localparam int SP = 8;
    localparam int DW = 24;
    localparam int QW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    wl_sel = 2'd0;
    logic [QW-1:0] quiet_in = '0;
    logic          l_empty = 1'b1;
    logic [DW-1:0] l_data = '0;
    logic          r_empty = 1'b1;
    logic [DW-1:0] r_data = '0;
    logic          l_pop, r_pop, dac_latch, dac_bclk, dac_sd_l, dac_sd_r;
    logic          l_underrun, r_underrun;

    dac_latch_fmt #(
        .WORD_PERIOD(WP), .LATCH_W(LW), .BIT_SPARE(SP), .DW(DW), .QW(QW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wl_sel(wl_sel), .quiet_in(quiet_in),
        .l_empty(l_empty), .l_data(l_data), .l_pop(l_pop),
        .r_empty(r_empty), .r_data(r_data), .r_pop(r_pop),
        .dac_latch(dac_latch), .dac_bclk(dac_bclk),
        .dac_sd_l(dac_sd_l), .dac_sd_r(dac_sd_r),
        .l_underrun(l_underrun), .r_underrun(r_underrun)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
        end
    endtask

    function automatic int m_bits(input int sel);
        return (sel == 0) ? 16 : (sel == 1) ? 18 : (sel == 2) ? 20 : 24;
    endfunction

    // Model state
    int qL[$];
    int qR[$];
    int t = 0;
    int m_len = 0, m_h = 1, m_q = 0, prev_len = 0;
    logic [DW-1:0] wL = '0, wR = '0, lastL = '0, lastR = '0;
    logic e_le = 0, e_bclk = 0, e_sdl = 0, e_sdr = 0, e_ufl = 0, e_ufr = 0;

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; lastL = '0; lastR = '0;
            e_le = 0; e_bclk = 0; e_sdl = 0; e_sdr = 0; e_ufl = 0; e_ufr = 0;
        end else begin
            int s;
            s = t % WP;
            if (s == 0) begin
                int qmax;
                prev_len = m_len;
                m_len = m_bits(int'(wl_sel));
                m_h = WP / (2 * (m_len + SP));
                qmax = (WP - LW) / (2 * m_h) - m_len;
                m_q = (int'(quiet_in) > qmax) ? qmax : int'(quiet_in);
                if (!l_empty) begin wL = l_data; lastL = l_data; void'(qL.pop_front()); e_ufl = 0; end
                else begin wL = lastL; e_ufl = 1; end
                if (!r_empty) begin wR = r_data; lastR = r_data; void'(qR.pop_front()); e_ufr = 0; end
                else begin wR = lastR; e_ufr = 1; end
            end
            e_le = (s < LW);
            e_bclk = 0;
            if (s >= LW) begin
                int u, cyc, ph, b;
                u = s - LW;
                cyc = u / (2 * m_h);
                ph = u % (2 * m_h);
                b = cyc - m_q;
                if (cyc >= m_q && b < m_len) begin
                    e_bclk = (ph >= m_h);
                    if (ph == 0) begin
                        e_sdl = wL[DW-1-b];
                        e_sdr = wR[DW-1-b];
                    end
                end
            end
            t++;
        end
    end

    // Compare on the falling edge, then present the FIFO heads
    logic prev_le = 0, prev_bclk = 0;
    int rises = 0, words = 0, qk = 0;
    bit qarm = 0;
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R11", "latch in reset", int'(dac_latch), 0);
                chk("R11", "bclk in reset", int'(dac_bclk), 0);
                chk("R11", "data/flags/pops in reset",
                    int'({dac_sd_l, dac_sd_r, l_underrun, r_underrun, l_pop, r_pop}), 0);
            end else begin
                chk("R1", "latch", int'(dac_latch), int'(e_le));
                chk("R3 R10", "bclk", int'(dac_bclk), int'(e_bclk));
                chk("R6 R9", "left data", int'(dac_sd_l), int'(e_sdl));
                chk("R6 R9", "right data", int'(dac_sd_r), int'(e_sdr));
                chk("R8", "left underrun", int'(l_underrun), int'(e_ufl));
                chk("R8", "right underrun", int'(r_underrun), int'(e_ufr));
                chk("R7", "left pop", int'(l_pop), int'((t % WP == 0) && !l_empty));
                chk("R7", "right pop", int'(r_pop), int'((t % WP == 0) && !r_empty));
                // Bit clock pulses per finished word
                if (dac_bclk && !prev_bclk) rises++;
                if (dac_latch && !prev_le) begin
                    if (words > 0) chk("R2 R10", "bits per word", rises, prev_len);
                    rises = 0;
                    words++;
                end
                // Quiet window from latch fall to first bit clock rise
                if (!dac_latch && prev_le) begin
                    qk = 0; qarm = 1;
                end else if (qarm) begin
                    qk++;
                    if (dac_bclk && !prev_bclk) begin
                        chk("R4 R5", "latch fall to first bclk rise", qk, m_q * 2 * m_h + m_h);
                        qarm = 0;
                    end
                end
            end
            prev_le = dac_latch;
            prev_bclk = dac_bclk;
            l_empty = (qL.size() == 0);
            l_data = (qL.size() == 0) ? '0 : DW'(qL[0]);
            r_empty = (qR.size() == 0);
            r_data = (qR.size() == 0) ? '0 : DW'(qR[0]);
        end
    end

    // Set the configuration, queue n words per channel, run n word periods
    task automatic run_words(input int n, input int sel, input int q);
        @(negedge clk);
        wl_sel = 2'(sel);
        quiet_in = QW'(q);
        for (int i = 0; i < n; i++) begin
            qL.push_back(int'($urandom & 32'hFF_FFFF));
            qR.push_back(int'($urandom & 32'hFF_FFFF));
        end
        repeat (n * WP) @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        // First word comes from an empty FIFO: repeat of zero (R8)
        repeat (WP + 37) @(negedge clk);
        // Edge patterns, then random words
        qL.push_back(24'hFF_FFFF); qR.push_back(24'h80_0001);
        qL.push_back(24'h80_0001); qR.push_back(24'hFF_FFFF);
        run_words(3, 0, 2);
        run_words(3, 1, 0);
        run_words(3, 2, 5);
        run_words(3, 3, 15);
        // Underrun: nothing queued for three words
        repeat (3 * WP) @(negedge clk);
        run_words(3, 0, 15);
        run_words(2, 1, 14);
        repeat (WP) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule